// File: doc/BRIEF.md
# Shared Frame Ring Lock Arbiter

This block sits between two frame-moving engines that share a ring of 2D frame buffers in memory: a writer engine that fills buffers from an incoming stream, and a reader engine that drains them to an outgoing stream. Each engine asks the arbiter to start a frame and reports when the frame is finished. At each start, the arbiter picks the buffer index that engine must use. It picks so that the two engines never hold the same buffer. When the rates differ, the writer drops a frame by rewriting its current buffer, or the reader repeats its previous buffer. Neither engine stalls on the other.

Software sets the ring length (as the index of the last buffer) and the reader lag (how many completed buffers the reader trails the writer by). Both values are captured when the block is enabled. For each side, a per-side option makes a start wait for an external frame-sync pulse. A shared autorun option makes each side start a new frame as soon as it is idle, with no start request.

Each side is run by its own sequencer with three states. SIDE_OFF is the state while the block is disabled. SIDE_ARM means the side is idle and waits for a start. SIDE_RUN means a frame is in progress. The transitions are:
- enable: SIDE_OFF to SIDE_ARM.
- start: SIDE_ARM to SIDE_RUN.
- finish: SIDE_RUN to SIDE_ARM.
- disable: any state to SIDE_OFF.

Top module: `bufring_lock_arb`

## Requirements
- R1: After reset, the following outputs are 0: `wr_busy`, `rd_busy`, `wr_dropped`, `rd_repeated` and `lag_hazard`.
- R2: The writer's first frame after enable uses buffer 0. Each later writer frame uses the previous index plus one, and wraps to 0 after the index `cfg_last_buf`, unless R4 applies.
- R3: A start that is accepted at a clock edge makes `busy` high and sets the granted index on that edge. A frame-done input seen while busy makes `busy` low on the next edge.
- R4: The reader keeps a claim on its most recently granted buffer, even while it is idle. If the writer's next index equals that claimed buffer, the writer keeps its current index and `wr_dropped` is high for exactly one cycle.
- R5: The reader may start only after the writer has completed at least lag+1 frames since enable. The reader is granted the index (last completed writer index − lag) modulo (`cfg_last_buf`+1). If the lag is greater than `cfg_last_buf`, it is clamped to `cfg_last_buf`.
- R6: If the reader's target equals the buffer the writer is currently filling, the reader is granted its previous index again. `rd_repeated` is high for one cycle whenever a reader grant equals the reader's previous index.
- R7: While `lag_hazard` is low, the two grants always differ whenever `wr_busy` and `rd_busy` are both high.
- R8: With a side's sync-enable high, that side starts only once both a start request and a sync pulse have been seen. Either of the two may arrive first; both are remembered until the start.
- R9: With `cfg_autorun` high, a side in SIDE_ARM starts without any start request.
- R10: The ring length and the lag are captured at enable. Changes made to them while the block is enabled have no effect.
- R11: While the block is enabled, `lag_hazard` is 1 exactly when the captured lag is greater than or equal to the captured `cfg_last_buf`.
- R12: If both sides could start on the same edge, the writer starts and the reader starts one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable; configuration is captured on its rise |
| cfg_last_buf | input | IDX_W | Index of the last buffer in the ring (buffer count − 1) |
| cfg_lag | input | IDX_W | Number of completed buffers the reader trails the writer by |
| cfg_autorun | input | 1 | Start frames without start requests |
| wr_sync_en | input | 1 | Writer starts wait for `wr_sync` |
| rd_sync_en | input | 1 | Reader starts wait for `rd_sync` |
| wr_start_req | input | 1 | Writer start request pulse |
| wr_sync | input | 1 | Writer external frame-sync pulse |
| wr_frame_done | input | 1 | Writer frame finished |
| rd_start_req | input | 1 | Reader start request pulse |
| rd_sync | input | 1 | Reader external frame-sync pulse |
| rd_frame_done | input | 1 | Reader frame finished |
| wr_busy | output | 1 | Writer frame in progress |
| wr_buf | output | IDX_W | Buffer index granted to the writer |
| wr_dropped | output | 1 | One-cycle pulse: the writer kept its buffer |
| rd_busy | output | 1 | Reader frame in progress |
| rd_buf | output | IDX_W | Buffer index granted to the reader |
| rd_repeated | output | 1 | One-cycle pulse: the reader got its previous buffer |
| lag_hazard | output | 1 | The configured lag can put the reader a full ring behind |

## Verification
Three delays set when each result can be checked:
- Start and grant: a request or sync presented before edge N gives `busy`, the index and the drop/repeat pulses after edge N.
- Enable: a rise of `cfg_enable` takes two edges to arm the sides.
- Reader gating: a writer completion unblocks the reader one edge later.

The bench drives inputs on the falling edge and checks on the next falling edge. It runs a cycle-accurate arithmetic model of these rules and compares every output on every cycle. Directed sequences then check sync gating, autorun, capture at enable, start priority, drop and repeat at the exact cycles worked out above.

// File: rtl/brl_pkg.sv
package brl_pkg;
    typedef enum logic [1:0] {
        SIDE_OFF = 2'd0,
        SIDE_ARM = 2'd1,
        SIDE_RUN = 2'd2
    } side_state_e;
endpackage

// File: rtl/brl_side_seq.sv
module brl_side_seq
    import brl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic autorun,
    input  logic sync_en,
    input  logic req,
    input  logic sync,
    input  logic allow,
    input  logic done,
    output logic start,
    output logic active
);
    side_state_e state_q, state_d;
    logic        pend_req_q, pend_sync_q;
    logic        go;

    // state register with the remembered request and sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SIDE_OFF;
            pend_req_q  <= 1'b0;
            pend_sync_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en || state_q == SIDE_OFF) begin
                pend_req_q  <= 1'b0;
                pend_sync_q <= 1'b0;
            end else begin
                pend_req_q  <= start ? 1'b0 : (pend_req_q | req);
                pend_sync_q <= start ? 1'b0 : (pend_sync_q | sync);
            end
        end
    end

    // next state and outputs
    always_comb begin
        go      = (autorun | pend_req_q | req) & (~sync_en | pend_sync_q | sync);
        start   = 1'b0;
        active  = (state_q == SIDE_RUN);
        state_d = state_q;
        if (!en) begin
            state_d = SIDE_OFF;
        end else begin
            unique case (state_q)
                SIDE_OFF: state_d = SIDE_ARM;
                SIDE_ARM: begin
                    if (go && allow) begin
                        start   = 1'b1;
                        state_d = SIDE_RUN;
                    end
                end
                SIDE_RUN: if (done) state_d = SIDE_ARM;
                default:  state_d = SIDE_OFF;
            endcase
        end
    end
endmodule

// File: rtl/brl_wr_pick.sv
module brl_wr_pick #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] rd_claim,
    input  logic             rd_claim_vld,
    output logic [IDX_W-1:0] grant,
    output logic             keep
);
    logic [IDX_W-1:0] step_idx;

    always_comb begin
        step_idx = (cur_idx == last_idx) ? '0 : cur_idx + IDX_W'(1);
        keep     = rd_claim_vld && (step_idx == rd_claim);
        grant    = keep ? cur_idx : step_idx;
    end
endmodule

// File: rtl/brl_rd_pick.sv
module brl_rd_pick #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] wr_last_done,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] lag,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_active,
    input  logic [IDX_W-1:0] prev_idx,
    input  logic             prev_vld,
    output logic [IDX_W-1:0] grant,
    output logic             again
);
    logic [IDX_W-1:0] target;
    logic             clash;

    // lag is already clamped to last_idx, so no term underflows
    always_comb begin
        if (wr_last_done >= lag) target = wr_last_done - lag;
        else                     target = wr_last_done + (last_idx - lag) + IDX_W'(1);
        clash = wr_active && (target == wr_idx);
        grant = clash ? prev_idx : target;
        again = prev_vld && (grant == prev_idx);
    end
endmodule

// File: rtl/bufring_lock_arb.sv
module bufring_lock_arb #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [IDX_W-1:0] cfg_last_buf,
    input  logic [IDX_W-1:0] cfg_lag,
    input  logic             cfg_autorun,
    input  logic             wr_sync_en,
    input  logic             rd_sync_en,
    input  logic             wr_start_req,
    input  logic             wr_sync,
    input  logic             wr_frame_done,
    input  logic             rd_start_req,
    input  logic             rd_sync,
    input  logic             rd_frame_done,
    output logic             wr_busy,
    output logic [IDX_W-1:0] wr_buf,
    output logic             wr_dropped,
    output logic             rd_busy,
    output logic [IDX_W-1:0] rd_buf,
    output logic             rd_repeated,
    output logic             lag_hazard
);
    localparam int         CNT_W   = IDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {IDX_W{1'b0}}};

    logic             en_q;
    logic [IDX_W-1:0] last_q, lag_q, lag_eff;
    logic [IDX_W-1:0] wr_idx_q, wr_done_q, rd_idx_q;
    logic             rd_have_q;
    logic [CNT_W-1:0] done_cnt_q;
    logic             wr_drop_q, rd_rep_q;

    logic             wr_start, rd_start, rd_allow, wr_finish;
    logic [IDX_W-1:0] wr_pick, rd_pick;
    logic             wr_keep, rd_again;

    assign lag_eff  = (lag_q > last_q) ? last_q : lag_q;
    assign rd_allow = (done_cnt_q > {1'b0, lag_eff}) && !wr_start;
    assign wr_finish = wr_busy && wr_frame_done;

    brl_side_seq u_wr_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .autorun(cfg_autorun),
        .sync_en(wr_sync_en), .req(wr_start_req), .sync(wr_sync),
        .allow(1'b1), .done(wr_frame_done), .start(wr_start), .active(wr_busy)
    );

    brl_side_seq u_rd_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .autorun(cfg_autorun),
        .sync_en(rd_sync_en), .req(rd_start_req), .sync(rd_sync),
        .allow(rd_allow), .done(rd_frame_done), .start(rd_start), .active(rd_busy)
    );

    brl_wr_pick #(.IDX_W(IDX_W)) u_wr_pick (
        .cur_idx(wr_idx_q), .last_idx(last_q), .rd_claim(rd_idx_q),
        .rd_claim_vld(rd_have_q), .grant(wr_pick), .keep(wr_keep)
    );

    brl_rd_pick #(.IDX_W(IDX_W)) u_rd_pick (
        .wr_last_done(wr_done_q), .last_idx(last_q), .lag(lag_eff),
        .wr_idx(wr_idx_q), .wr_active(wr_busy), .prev_idx(rd_idx_q),
        .prev_vld(rd_have_q), .grant(rd_pick), .again(rd_again)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            last_q     <= '0;
            lag_q      <= '0;
            wr_idx_q   <= '0;
            wr_done_q  <= '0;
            rd_idx_q   <= '0;
            rd_have_q  <= 1'b0;
            done_cnt_q <= '0;
            wr_drop_q  <= 1'b0;
            rd_rep_q   <= 1'b0;
        end else begin
            en_q      <= cfg_enable;
            wr_drop_q <= 1'b0;
            rd_rep_q  <= 1'b0;
            if (!en_q) begin
                // configuration follows the inputs only while disabled
                last_q     <= cfg_last_buf;
                lag_q      <= cfg_lag;
                wr_idx_q   <= cfg_last_buf;
                wr_done_q  <= '0;
                rd_idx_q   <= '0;
                rd_have_q  <= 1'b0;
                done_cnt_q <= '0;
            end else begin
                if (wr_start) begin
                    wr_idx_q  <= wr_pick;
                    wr_drop_q <= wr_keep;
                end
                if (wr_finish) begin
                    wr_done_q <= wr_idx_q;
                    if (done_cnt_q != CNT_MAX) done_cnt_q <= done_cnt_q + CNT_W'(1);
                end
                if (rd_start) begin
                    rd_idx_q  <= rd_pick;
                    rd_have_q <= 1'b1;
                    rd_rep_q  <= rd_again;
                end
            end
        end
    end

    assign wr_buf      = wr_idx_q;
    assign rd_buf      = rd_idx_q;
    assign wr_dropped  = wr_drop_q;
    assign rd_repeated = rd_rep_q;
    assign lag_hazard  = en_q && (lag_q >= last_q);
endmodule

// File: rtl/brl_checks.sv
module brl_checks #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_busy,
    input logic [IDX_W-1:0] wr_buf,
    input logic             wr_dropped,
    input logic             rd_busy,
    input logic [IDX_W-1:0] rd_buf,
    input logic             rd_repeated,
    input logic             lag_hazard,
    input logic [IDX_W-1:0] ring_last
);
    a_r7_no_shared_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && rd_busy && !lag_hazard) |-> (wr_buf != rd_buf));

    a_r4_drop_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |-> (wr_busy && wr_buf == $past(wr_buf)));

    a_r4_drop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |=> !wr_dropped);

    a_r2_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_busy) && !wr_dropped) |->
        (wr_buf == (($past(wr_buf) == ring_last) ? '0 : IDX_W'($past(wr_buf) + IDX_W'(1)))));

    a_r6_repeat_same_buf: assert property (@(posedge clk) disable iff (!rst_n)
        rd_repeated |-> (rd_busy && rd_buf == $past(rd_buf)));
endmodule

bind bufring_lock_arb brl_checks #(.IDX_W(IDX_W)) u_brl_checks (
    .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .wr_buf(wr_buf),
    .wr_dropped(wr_dropped), .rd_busy(rd_busy), .rd_buf(rd_buf),
    .rd_repeated(rd_repeated), .lag_hazard(lag_hazard), .ring_last(last_q)
);

// File: tb/bufring_lock_arb_tb_top.sv
module bufring_lock_arb_tb_top;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic cfg_enable, cfg_autorun, wr_sync_en, rd_sync_en;
    logic [IW-1:0] cfg_last_buf, cfg_lag;
    logic wr_start_req, wr_sync, wr_frame_done, rd_start_req, rd_sync, rd_frame_done;
    logic wr_busy, wr_dropped, rd_busy, rd_repeated, lag_hazard;
    logic [IW-1:0] wr_buf, rd_buf;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit chk_on = 0;
    logic [31:0] rs = 32'h1badf00d;

    bufring_lock_arb #(.IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_last_buf(cfg_last_buf),
        .cfg_lag(cfg_lag), .cfg_autorun(cfg_autorun), .wr_sync_en(wr_sync_en),
        .rd_sync_en(rd_sync_en), .wr_start_req(wr_start_req), .wr_sync(wr_sync),
        .wr_frame_done(wr_frame_done), .rd_start_req(rd_start_req), .rd_sync(rd_sync),
        .rd_frame_done(rd_frame_done), .wr_busy(wr_busy), .wr_buf(wr_buf),
        .wr_dropped(wr_dropped), .rd_busy(rd_busy), .rd_buf(rd_buf),
        .rd_repeated(rd_repeated), .lag_hazard(lag_hazard)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: 0 off, 1 armed, 2 running
    bit m_en, m_wpr, m_wps, m_rpr, m_rps, m_rhave, m_drop, m_rep;
    int m_ws, m_rs, m_last, m_lag, m_widx, m_wdone, m_ridx, m_cnt;

    always @(posedge clk) begin : mdl
        int le, nxt, tgt, wg, rg;
        bit wgo, rgo, wst, rst2, wblk, rcol;
        if (!rst_n) begin
            m_en = 0; m_ws = 0; m_rs = 0; m_wpr = 0; m_wps = 0; m_rpr = 0; m_rps = 0;
            m_last = 0; m_lag = 0; m_widx = 0; m_wdone = 0; m_ridx = 0; m_rhave = 0;
            m_cnt = 0; m_drop = 0; m_rep = 0;
        end else begin
            le   = (m_lag > m_last) ? m_last : m_lag;
            wgo  = (cfg_autorun || m_wpr || wr_start_req) && (!wr_sync_en || m_wps || wr_sync);
            rgo  = (cfg_autorun || m_rpr || rd_start_req) && (!rd_sync_en || m_rps || rd_sync);
            wst  = m_en && m_ws == 1 && wgo;
            rst2 = m_en && m_rs == 1 && rgo && (m_cnt > le) && !wst;
            nxt  = (m_widx == m_last) ? 0 : m_widx + 1;
            wblk = m_rhave && nxt == m_ridx;
            wg   = wblk ? m_widx : nxt;
            tgt  = (m_wdone >= le) ? m_wdone - le : m_wdone + m_last + 1 - le;
            rcol = (m_ws == 2) && tgt == m_widx;
            rg   = rcol ? m_ridx : tgt;
            m_drop = 0; m_rep = 0;
            if (!m_en) begin
                m_ws = 0; m_rs = 0; m_wpr = 0; m_wps = 0; m_rpr = 0; m_rps = 0;
                m_last = int'(cfg_last_buf); m_lag = int'(cfg_lag); m_widx = int'(cfg_last_buf);
                m_wdone = 0; m_ridx = 0; m_rhave = 0; m_cnt = 0;
            end else begin
                if (m_ws == 0) begin
                    m_ws = 1; m_wpr = 0; m_wps = 0;
                end else begin
                    m_wpr = wst ? 0 : (m_wpr | wr_start_req);
                    m_wps = wst ? 0 : (m_wps | wr_sync);
                    if (wst) begin
                        m_ws = 2; m_widx = wg; m_drop = wblk;
                    end else if (m_ws == 2 && wr_frame_done) begin
                        m_ws = 1; m_wdone = m_widx;
                        if (m_cnt < (1 << IW)) m_cnt++;
                    end
                end
                if (m_rs == 0) begin
                    m_rs = 1; m_rpr = 0; m_rps = 0;
                end else begin
                    m_rpr = rst2 ? 0 : (m_rpr | rd_start_req);
                    m_rps = rst2 ? 0 : (m_rps | rd_sync);
                    if (rst2) begin
                        m_rs = 2; m_rep = m_rhave && rg == m_ridx; m_ridx = rg; m_rhave = 1;
                    end else if (m_rs == 2 && rd_frame_done) begin
                        m_rs = 1;
                    end
                end
            end
            m_en = cfg_enable;
        end
    end

    // cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            chk("R3 wr_busy", int'(wr_busy), int'(m_ws == 2));
            chk("R2 wr_buf", int'(wr_buf), m_widx);
            chk("R4 wr_dropped", int'(wr_dropped), int'(m_drop));
            chk("R5 rd_busy", int'(rd_busy), int'(m_rs == 2));
            chk("R5 rd_buf", int'(rd_buf), m_ridx);
            chk("R6 rd_repeated", int'(rd_repeated), int'(m_rep));
            chk("R11 lag_hazard", int'(lag_hazard), int'(m_en && m_lag >= m_last));
            if (wr_busy && rd_busy && !(m_lag >= m_last))
                chk("R7 shared buffer", int'(wr_buf == rd_buf), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_in();
        wr_start_req = 0; rd_start_req = 0; wr_frame_done = 0; rd_frame_done = 0;
        wr_sync = 0; rd_sync = 0;
    endtask

    task automatic configure(input int last, input int lag, input bit au, input bit wse, input bit rse);
        cfg_enable = 0; clr_in(); step(2);
        cfg_last_buf = IW'(last); cfg_lag = IW'(lag);
        cfg_autorun = au; wr_sync_en = wse; rd_sync_en = rse;
        cfg_enable = 1; step(2);
    endtask

    task automatic wr_req_p();  wr_start_req = 1;  step(1); wr_start_req = 0;  endtask
    task automatic wr_done_p(); wr_frame_done = 1; step(1); wr_frame_done = 0; endtask
    task automatic rd_req_p();  rd_start_req = 1;  step(1); rd_start_req = 0;  endtask
    task automatic rd_done_p(); rd_frame_done = 1; step(1); rd_frame_done = 0; endtask

    initial begin
        rst_n = 0; cfg_enable = 0; cfg_autorun = 0; wr_sync_en = 0; rd_sync_en = 0;
        cfg_last_buf = '0; cfg_lag = '0; clr_in();
        step(3);
        chk("R1 wr_busy reset", int'(wr_busy), 0);
        chk("R1 rd_busy reset", int'(rd_busy), 0);
        chk("R1 wr_dropped reset", int'(wr_dropped), 0);
        chk("R1 rd_repeated reset", int'(rd_repeated), 0);
        chk("R1 lag_hazard reset", int'(lag_hazard), 0);
        rst_n = 1; chk_on = 1;
        step(2);

        // R9 autorun and R10 capture at enable
        configure(3, 0, 1, 0, 1);
        chk("R9 not started before arm", int'(wr_busy), 0);
        step(1);
        chk("R9 autorun start", int'(wr_busy), 1);
        chk("R9 first buffer", int'(wr_buf), 0);
        wr_done_p();
        chk("R3 busy drops after done", int'(wr_busy), 0);
        step(1);
        chk("R9 restart", int'(wr_busy), 1);
        chk("R2 second buffer", int'(wr_buf), 1);
        cfg_last_buf = IW'(1);
        for (int k = 0; k < 3; k++) begin
            wr_done_p(); step(1);
            chk("R10 ring length held", int'(wr_buf), (k + 2) % 4);
        end

        // R12 priority, R4 drop, R6 repeat
        configure(3, 0, 0, 0, 0);
        wr_req_p();
        chk("R3 start grant busy", int'(wr_busy), 1);
        chk("R2 first buffer", int'(wr_buf), 0);
        wr_done_p();
        wr_start_req = 1; rd_start_req = 1; step(1); wr_start_req = 0; rd_start_req = 0;
        chk("R12 writer wins", int'(wr_busy), 1);
        chk("R12 writer buffer", int'(wr_buf), 1);
        chk("R12 reader waits", int'(rd_busy), 0);
        step(1);
        chk("R12 reader next edge", int'(rd_busy), 1);
        chk("R5 reader target", int'(rd_buf), 0);
        wr_done_p(); wr_req_p();
        chk("R2 step to 2", int'(wr_buf), 2);
        wr_done_p(); wr_req_p();
        chk("R2 step to 3", int'(wr_buf), 3);
        wr_done_p(); wr_req_p();
        chk("R4 writer keeps buffer", int'(wr_buf), 3);
        chk("R4 drop pulse", int'(wr_dropped), 1);
        step(1);
        chk("R4 drop one cycle", int'(wr_dropped), 0);
        rd_done_p(); rd_req_p();
        chk("R6 reader busy", int'(rd_busy), 1);
        chk("R6 reader previous buffer", int'(rd_buf), 0);
        chk("R6 repeat pulse", int'(rd_repeated), 1);

        // R8 sync gating
        configure(3, 0, 0, 1, 0);
        wr_req_p(); step(3);
        chk("R8 waits for sync", int'(wr_busy), 0);
        wr_sync = 1; step(1); wr_sync = 0;
        chk("R8 start on sync", int'(wr_busy), 1);
        chk("R8 buffer", int'(wr_buf), 0);

        // R5 reader gating by completed writer frames
        configure(7, 2, 0, 0, 0);
        wr_req_p(); wr_done_p(); wr_req_p(); wr_done_p();
        rd_req_p();
        chk("R5 reader blocked", int'(rd_busy), 0);
        wr_req_p(); wr_done_p();
        chk("R5 still blocked", int'(rd_busy), 0);
        step(1);
        chk("R5 reader starts", int'(rd_busy), 1);
        chk("R5 lag target", int'(rd_buf), 0);

        // R11 hazard flag
        configure(2, 2, 0, 0, 0);
        chk("R11 hazard set", int'(lag_hazard), 1);
        configure(2, 1, 0, 0, 0);
        chk("R11 hazard clear", int'(lag_hazard), 0);

        // sweep over ring length, lag and start modes against the model
        for (int md = 0; md < 2; md++) begin
            for (int ls = 1; ls < 8; ls++) begin
                for (int lg = 0; lg < 8; lg++) begin
                    configure(ls, lg, md == 1, md == 1, md == 1);
                    for (int c = 0; c < 140; c++) begin
                        rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
                        wr_start_req  = (rs[1:0] == 2'd0);
                        wr_frame_done = (rs[4:2] == 3'd0);
                        rd_start_req  = (rs[6:5] == 2'd0);
                        rd_frame_done = (rs[9:7] == 3'd0);
                        wr_sync       = (rs[12:10] == 3'd0);
                        rd_sync       = (rs[15:13] == 3'd0);
                        step(1);
                    end
                end
            end
        end
        clr_in(); step(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule